// File: doc/BRIEF.md
# Least-Loaded Token Dispatch Mapper

This block steers process request tokens to processing elements (PEs). Each token carries a process number and an opaque payload. An ownership table, held in on-chip storage and loaded through a write port, lists for every process number the PEs that hold a copy of that process. The block combines that list with a live availability vector. Among the PEs that are both owners and available, it picks the one that reports the shallowest input queue. Queue depth is used as the measure of how long a token will wait before it runs.

The token leaves on a valid/ready output, tagged with the binary index of the chosen PE. A request that no PE can serve is dropped. It raises a one-cycle fault pulse that carries its process number.

The block is a three-register pipeline: table read, then depth comparison, then output. The whole pipeline advances together. It stalls as a unit when the output is not taken, so no token is lost or repeated.

Top module: `token_dispatch_mapper`

## Requirements
- R1: After reset, `out_valid` and `fault_pulse` are low and `in_ready` is high. Every ownership mask is cleared, so any request made before the table is written produces a fault.
- R2: A table write stores `tbl_wr_mask` for process `tbl_wr_id`; bit k set means PE k owns the process. A request accepted in the same cycle as a write to its process number sees the old mask. Later requests see the new mask.
- R3: The chosen PE is always one whose mask bit and `pe_avail` bit are both set. Its depth, `pe_depth[k*5 +: 5]` for PE k, is the smallest among those PEs.
- R4: When several candidate PEs share the smallest depth, the one with the lowest index is chosen.
- R5: A PE whose `pe_avail` bit is low is never chosen, even when its depth is the smallest of all owners.
- R6: A token accepted at a rising edge (`in_valid` and `in_ready` high) appears on the output after the third rising edge, counting the accepting edge as the first. It appears with its own `in_id` and `in_payload`, and `out_pe` holds the index of the chosen PE.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields stay unchanged. Every accepted token is delivered exactly once, in acceptance order.
- R8: A request with no PE that is both an owner and available raises `fault_pulse` for exactly one cycle, at the cycle in which its token would have appeared, with `fault_id` equal to its process number. No token is sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_wr_en | input | 1 | Ownership table write strobe |
| tbl_wr_id | input | 4 | Process number to write |
| tbl_wr_mask | input | 8 | Owner bitmask, bit k for PE k |
| pe_avail | input | 8 | Availability per PE, 1 = may be chosen |
| pe_depth | input | 40 | Queue depth per PE, 5 bits each, PE k at bits k*5 upward |
| in_valid | input | 1 | Request token present |
| in_ready | output | 1 | Block accepts a token this cycle |
| in_id | input | 4 | Requested process number |
| in_payload | input | 8 | Opaque token contents |
| out_valid | output | 1 | Routed token present |
| out_ready | input | 1 | Downstream takes the token |
| out_pe | output | 3 | Index of the chosen PE |
| out_id | output | 4 | Process number of the routed token |
| out_payload | output | 8 | Contents of the routed token |
| fault_pulse | output | 1 | One-cycle flag for an unservable request |
| fault_id | output | 4 | Process number of the faulting request |

## Verification
The bench builds the block with its default parameters: eight PEs, sixteen process numbers, five-bit depths and an eight-bit payload. With these values the full depth range is reachable, from 0 up to the ceiling of 31. Both the highest and the lowest PE index can win, and every process number can be written and requested directly. The small table also lets the bench check the cleared-after-reset state and a write racing a read of the same entry.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   localparam int unsigned TDM_NPE_DEF   = 8;
   localparam int unsigned TDM_IDW_DEF   = 4;
   localparam int unsigned TDM_DEPW_DEF  = 5;
   localparam int unsigned TDM_PAYW_DEF  = 8;

   function automatic int unsigned tdm_idx_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tdm_owner_table.sv
module tdm_owner_table #(
   parameter int unsigned NPE = 8,
   parameter int unsigned IDW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [IDW-1:0] wr_id,
   input  logic [NPE-1:0] wr_mask,
   input  logic           rd_en,
   input  logic [IDW-1:0] rd_id,
   output logic [NPE-1:0] rd_mask
);
   localparam int unsigned NPROC = 1 << IDW;

   logic [NPE-1:0] own_q [NPROC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPROC; i++) own_q[i] <= '0;
      end else if (wr_en) begin
         own_q[wr_id] <= wr_mask;
      end
   end

   // read sees the entry as it was before a write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_mask <= '0;
      else if (rd_en) rd_mask <= own_q[rd_id];
   end
endmodule

// File: rtl/tdm_least_pick.sv
module tdm_least_pick #(
   parameter int unsigned NPE  = 8,
   parameter int unsigned DEPW = 5,
   parameter int unsigned PEW  = 3
) (
   input  logic [NPE-1:0]      cand,
   input  logic [NPE*DEPW-1:0] depth_flat,
   output logic                any,
   output logic [PEW-1:0]      idx
);
   logic [DEPW-1:0] dep [NPE];
   logic [DEPW-1:0] best;

   for (genvar g = 0; g < NPE; g++) begin : g_unpack
      assign dep[g] = depth_flat[g*DEPW +: DEPW];
   end

   // strict less-than: on equal depths the earlier (lower) index stays
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      best = '1;
      for (int i = 0; i < NPE; i++) begin
         if (cand[i] && (!any || dep[i] < best)) begin
            any  = 1'b1;
            best = dep[i];
            idx  = PEW'(i);
         end
      end
   end
endmodule

// File: rtl/token_dispatch_mapper.sv
module token_dispatch_mapper
   import tdm_pkg::*;
#(
   parameter int unsigned NPE  = TDM_NPE_DEF,
   parameter int unsigned IDW  = TDM_IDW_DEF,
   parameter int unsigned DEPW = TDM_DEPW_DEF,
   parameter int unsigned PAYW = TDM_PAYW_DEF,
   localparam int unsigned PEW = tdm_idx_w(NPE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tbl_wr_en,
   input  logic [IDW-1:0]      tbl_wr_id,
   input  logic [NPE-1:0]      tbl_wr_mask,
   input  logic [NPE-1:0]      pe_avail,
   input  logic [NPE*DEPW-1:0] pe_depth,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [IDW-1:0]      in_id,
   input  logic [PAYW-1:0]     in_payload,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [PEW-1:0]      out_pe,
   output logic [IDW-1:0]      out_id,
   output logic [PAYW-1:0]     out_payload,
   output logic                fault_pulse,
   output logic [IDW-1:0]      fault_id
);
   if (NPE < 2)  begin : g_chk_npe  $error("NPE must be at least 2");  end
   if (IDW < 1)  begin : g_chk_idw  $error("IDW must be at least 1");  end
   if (DEPW < 1) begin : g_chk_depw $error("DEPW must be at least 1"); end
   if (PAYW < 1) begin : g_chk_payw $error("PAYW must be at least 1"); end

   logic advance;
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   // stage 1: table read
   logic            s1_valid;
   logic [IDW-1:0]  s1_id;
   logic [PAYW-1:0] s1_pay;
   logic [NPE-1:0]  s1_mask;

   tdm_owner_table #(.NPE(NPE), .IDW(IDW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr_en), .wr_id(tbl_wr_id), .wr_mask(tbl_wr_mask),
      .rd_en(advance), .rd_id(in_id), .rd_mask(s1_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_id    <= '0;
         s1_pay   <= '0;
      end else if (advance) begin
         s1_valid <= in_valid;
         s1_id    <= in_id;
         s1_pay   <= in_payload;
      end
   end

   // stage 2: availability filter and depth comparison
   logic [NPE-1:0] cand;
   logic           pick_any;
   logic [PEW-1:0] pick_idx;

   assign cand = s1_mask & pe_avail;

   tdm_least_pick #(.NPE(NPE), .DEPW(DEPW), .PEW(PEW)) u_pick (
      .cand(cand), .depth_flat(pe_depth), .any(pick_any), .idx(pick_idx)
   );

   logic            s2_valid, s2_fault;
   logic [PEW-1:0]  s2_pe;
   logic [IDW-1:0]  s2_id;
   logic [PAYW-1:0] s2_pay;
   logic [NPE-1:0]  s2_cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_fault <= 1'b0;
         s2_pe    <= '0;
         s2_id    <= '0;
         s2_pay   <= '0;
         s2_cand  <= '0;
      end else if (advance) begin
         s2_valid <= s1_valid;
         s2_fault <= !pick_any;
         s2_pe    <= pick_idx;
         s2_id    <= s1_id;
         s2_pay   <= s1_pay;
         s2_cand  <= cand;
      end
   end

   // stage 3: route / fault report
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_pe      <= '0;
         out_id      <= '0;
         out_payload <= '0;
         fault_pulse <= 1'b0;
         fault_id    <= '0;
      end else if (advance) begin
         out_valid   <= s2_valid && !s2_fault;
         out_pe      <= s2_pe;
         out_id      <= s2_id;
         out_payload <= s2_pay;
         fault_pulse <= s2_valid && s2_fault;
         fault_id    <= s2_id;
      end else begin
         fault_pulse <= 1'b0;
      end
   end

   p_pick_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !s2_fault) |-> s2_cand[s2_pe]);

   p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pe)
                                     && $stable(out_id) && $stable(out_payload)));

   p_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_fault_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> !out_valid);

   p_fault_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_pulse && !$past(advance)) |-> 1'b0);
endmodule

// File: tb/token_dispatch_mapper_tb_top.sv
module token_dispatch_mapper_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]  id;
      logic [7:0]  avail;
      logic [39:0] dep;
      logic        fault;
      logic [2:0]  pe;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{4'd0, 8'hFF, {5'd10,5'd3,5'd4,5'd5,5'd6,5'd7,5'd8,5'd9},      1'b0, 3'd6},
      '{4'd0, 8'hFF, {8{5'd4}},                                         1'b0, 3'd0},
      '{4'd1, 8'hFF, {5'd1,5'd1,5'd1,5'd1,5'd1,5'd12,5'd12,5'd0},     1'b0, 3'd1},
      '{4'd1, 8'hFD, {5'd0,5'd0,5'd0,5'd0,5'd0,5'd20,5'd0,5'd0},      1'b0, 3'd2},
      '{4'd2, 8'hFF, {5'd30,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd31},     1'b0, 3'd7},
      '{4'd2, 8'h7E, {8{5'd0}},                                         1'b1, 3'd0},
      '{4'd3, 8'hFF, {8{5'd0}},                                         1'b1, 3'd0},
      '{4'd5, 8'hFF, {5'd0,5'd0,5'd0,5'd31,5'd0,5'd0,5'd0,5'd0},      1'b0, 3'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_wr_en = 1'b0;
   logic [3:0]  tbl_wr_id = '0;
   logic [7:0]  tbl_wr_mask = '0;
   logic [7:0]  pe_avail = '0;
   logic [39:0] pe_depth = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_id = '0;
   logic [7:0]  in_payload = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [2:0]  out_pe;
   logic [3:0]  out_id;
   logic [7:0]  out_payload;
   logic        fault_pulse;
   logic [3:0]  fault_id;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   token_dispatch_mapper dut_i (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_id(tbl_wr_id), .tbl_wr_mask(tbl_wr_mask),
      .pe_avail(pe_avail), .pe_depth(pe_depth),
      .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_payload(in_payload),
      .out_valid(out_valid), .out_ready(out_ready), .out_pe(out_pe),
      .out_id(out_id), .out_payload(out_payload),
      .fault_pulse(fault_pulse), .fault_id(fault_id)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic write_tbl(input logic [3:0] id, input logic [7:0] m);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_id = id; tbl_wr_mask = m;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   task automatic send(input logic [3:0] id, input logic [7:0] pay);
      bit ok;
      in_valid = 1'b1; in_id = id; in_payload = pay;
      forever begin
         ok = in_ready;
         @(negedge clk);
         if (ok) break;
      end
      in_valid = 1'b0;
   endtask

   // called at a negedge; token accepted at the following edge
   task automatic one_shot(input logic [3:0] id, input logic [7:0] pay,
                           input bit exp_fault, input logic [2:0] exp_pe, input string req);
      send(id, pay);
      @(negedge clk);
      check(!out_valid && !fault_pulse, {req, " early"}, int'(out_valid), 0);
      @(negedge clk);
      if (exp_fault) begin
         check(fault_pulse == 1'b1, {req, " fault"}, int'(fault_pulse), 1);
         check(fault_id == id, {req, " fault_id"}, int'(fault_id), int'(id));
         check(out_valid == 1'b0, {req, " no token"}, int'(out_valid), 0);
      end else begin
         check(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
         check(out_pe == exp_pe, {req, " pe"}, int'(out_pe), int'(exp_pe));
         check(out_id == id && out_payload == pay, {req, " fields"},
               int'(out_payload), int'(pay));
      end
      @(negedge clk);
      check(!fault_pulse && !out_valid, {req, " clear"}, int'(fault_pulse), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
   end

   initial begin
      // R1: reset state
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check(!out_valid && !fault_pulse, "R1 outputs idle", int'(out_valid), 0);
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      pe_avail = 8'hFF;
      one_shot(4'd9, 8'h11, 1'b1, 3'd0, "R1 cleared table");

      // R2: write racing a read of the same entry sees the old mask
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_id = 4'd6; tbl_wr_mask = 8'h08;
      in_valid = 1'b1; in_id = 4'd6; in_payload = 8'h22;
      @(negedge clk);
      tbl_wr_en = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(fault_pulse == 1'b1, "R2 old mask read", int'(fault_pulse), 1);
      @(negedge clk);
      one_shot(4'd6, 8'h23, 1'b0, 3'd3, "R2 new mask");

      // load table for vector walk
      write_tbl(4'd0, 8'hFF);
      write_tbl(4'd1, 8'h06);
      write_tbl(4'd2, 8'h81);
      write_tbl(4'd3, 8'h00);
      write_tbl(4'd5, 8'h10);

      // R3 R4 R5 R6 R8 vector walk
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         pe_avail = VECS[i].avail;
         pe_depth = VECS[i].dep;
         one_shot(VECS[i].id, 8'hA0 + 8'(i), VECS[i].fault, VECS[i].pe,
                  $sformatf("R3/R4/R5/R6/R8 vec%0d", i));
      end

      // R7: backpressure, two tokens, each delivered once in order
      @(negedge clk);
      pe_avail = 8'hFF;
      pe_depth = VECS[0].dep;
      out_ready = 1'b0;
      send(4'd0, 8'h5A);
      send(4'd0, 8'h5B);
      repeat (4) @(negedge clk);
      check(out_valid && out_payload == 8'h5A, "R7 stalled head", int'(out_payload), 8'h5A);
      check(in_ready == 1'b0, "R7 in_ready low", int'(in_ready), 0);
      repeat (3) @(negedge clk);
      check(out_valid && out_payload == 8'h5A && out_pe == 3'd6, "R7 held stable",
            int'(out_payload), 8'h5A);
      out_ready = 1'b1;
      begin
         int na = 0, nb = 0;
         bit order_ok = 1'b1;
         for (int k = 0; k < 6; k++) begin
            if (out_valid) begin
               if (out_payload == 8'h5A) begin
                  na++;
                  if (nb != 0) order_ok = 1'b0;
               end else if (out_payload == 8'h5B) nb++;
            end
            @(negedge clk);
         end
         check(na == 1, "R7 first token once", na, 1);
         check(nb == 1, "R7 second token once", nb, 1);
         check(order_ok, "R7 order", int'(order_ok), 1);
      end

      report();
   end
endmodule